// File: doc/BRIEF.md
# Parallel ATA PIO Register-Cycle Sequencer

This block runs one programmed-I/O register read or write on a parallel ATA style device bus, acting for the host. A requester raises `req` with a register address, an 8-bit write value, a direction bit and a transfer mode from 0 to 4. The sequencer drives the address lines, and then the active-low read or write strobe. It enables the host data driver only while that is safe. It watches the device ready line and pulses `ack` once the whole cycle, including the recovery gap, is over.

All bus intervals are nanosecond minimums, one set per mode, turned into clock counts at elaboration time. Each count is `ceil(ns / CLK_NS)` with a floor of one cycle. The strobe width and the inactive time are each chosen per mode. The inactive time is then stretched, where needed, until strobe width plus inactive time reaches the minimum cycle time. A device may stretch the strobe by holding ready low. If it holds ready low too long, the cycle is ended anyway and flagged.

Top module: `pio_seq`

## Requirements
- R1: While `rst` is high, and on the first cycles after it falls, `bus_rd_n` and `bus_wr_n` are 1, and `bus_oe` and `ack` are 0.
- R2: A request is taken in the cycle after `req` is seen high while idle. The address is then driven for exactly ceil(70,50,30,30,25 ns / CLK_NS) cycles (modes 0..4) before any strobe goes low. `req_wr`=1 selects a write, which uses `bus_wr_n` only; 0 selects a read, which uses `bus_rd_n` only. `bus_addr` stays constant from acceptance until the next request.
- R3: With ready high, the strobe stays low for exactly ceil(290,290,290,80,70 ns / CLK_NS) cycles.
- R4: After the strobe rises, the bus stays inactive for H + max(1, I - H) cycles before `ack`. Here H is the hold count of R5 or R10, and I = max(ceil(t2i), ceil(t0) - strobe cycles). t0 is 600,383,240,180,120 ns and t2i is 0,0,0,70,25 ns. Strobe plus inactive cycles is therefore at least ceil(t0).
- R5: On a write, `bus_oe`=1 and `bus_dout` equals the request's write data from acceptance until ceil(max(30,20,15,10,10 ns ; 20,15,10,10,10 ns)/CLK_NS) cycles after the strobe rises. The hold count is the larger of the data hold and the address hold.
- R6: On a read, `ack_rdata` returns the `bus_din` value present in the last strobe-low cycle.
- R7: `bus_rdy` is sampled once, in strobe cycle ceil(35 ns / CLK_NS). If it was low there and is still low when the minimum width ends, the strobe stays low up to and including the first cycle in which ready is high.
- R8: A low on `bus_rdy` outside the sample cycle, or one that is gone by the end of the minimum width, has no effect on the strobe width.
- R9: If ready is still low after ceil(1250 ns / CLK_NS) extension cycles, the strobe ends anyway. The cycle completes, and `ack_timeout`=1 with `ack`; a read still returns `bus_din`. Otherwise `ack_timeout`=0.
- R10: On a read, `bus_oe` is 0 during the strobe and for at least ceil(30 ns / CLK_NS) cycles after it. The read hold count is ceil(max(addr hold, 30 ns)/CLK_NS).
- R11: `ack` is high for exactly one cycle, at the end of recovery. The requester drops `req` in that cycle, and a new request may follow at once.
- R12: Mode values 5, 6 and 7 use the mode 4 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request a register cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_mode | input | 3 | Transfer mode 0..4 (5..7 act as 4) |
| req_addr | input | AW | Register address |
| req_wdata | input | DW | Write value |
| ack | output | 1 | One-cycle completion pulse |
| ack_timeout | output | 1 | Ready wait expired, valid with ack |
| ack_rdata | output | DW | Read value, valid with ack |
| bus_addr | output | AW | Device address lines |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_dout | output | DW | Host data toward the device |
| bus_oe | output | 1 | Host data driver enable |
| bus_din | input | DW | Data from the device |
| bus_rdy | input | 1 | Device ready, low stretches the strobe |

## Verification
On every cycle, the assertions check several rules. The two strobes are never low together. The address does not move inside a transaction, and no strobe ends before its mode's minimum width. Ready extension never exceeds its bound. The host driver stays off during a read strobe and through the device release window, and `ack` is a single-cycle pulse. Only the bench's scenarios can show the exact counts, which depend on the mode: setup, width, hold and recovery for all five modes in both directions. The same goes for the captured read value, and for which ready waveforms stretch the strobe and which are ignored. The timeout path and mode clamping are likewise shown only by the scenarios.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

    localparam int CW        = 12;
    localparam int NUM_MODES = 5;

    localparam int RD_RELEASE_NS = 30;
    localparam int RDY_SAMPLE_NS = 35;
    localparam int RDY_MAX_NS    = 1250;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR_SETUP,
        PH_STROBE,
        PH_WAIT_READY,
        PH_HOLD,
        PH_RECOVERY
    } phase_t;

    typedef struct packed {
        logic [CW-1:0] setup;
        logic [CW-1:0] active;
        logic [CW-1:0] hold;
        logic [CW-1:0] recov;
        logic [CW-1:0] rdy_at;
        logic [CW-1:0] rdy_max;
    } pio_timing_t;

    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cycle_min_ns(input int m);
        case (m)
            0: return 600;
            1: return 383;
            2: return 240;
            3: return 180;
            default: return 120;
        endcase
    endfunction

    function automatic int addr_setup_ns(input int m);
        case (m)
            0: return 70;
            1: return 50;
            2, 3: return 30;
            default: return 25;
        endcase
    endfunction

    function automatic int strobe_ns(input int m);
        case (m)
            0, 1, 2: return 290;
            3: return 80;
            default: return 70;
        endcase
    endfunction

    function automatic int recover_ns(input int m);
        case (m)
            3: return 70;
            4: return 25;
            default: return 0;
        endcase
    endfunction

    function automatic int wdata_hold_ns(input int m);
        case (m)
            0: return 30;
            1: return 20;
            2: return 15;
            default: return 10;
        endcase
    endfunction

    function automatic int addr_hold_ns(input int m);
        case (m)
            0: return 20;
            1: return 15;
            default: return 10;
        endcase
    endfunction

    // Convert one mode's nanosecond limits into clock counts for one direction.
    function automatic pio_timing_t mode_timing(input int m, input logic wr, input int clk_ns);
        pio_timing_t t;
        int act;
        int hold;
        int inact;
        int rec;
        act  = ns_to_cyc(strobe_ns(m), clk_ns);
        hold = wr ? ns_to_cyc(imax(wdata_hold_ns(m), addr_hold_ns(m)), clk_ns)
                  : ns_to_cyc(imax(addr_hold_ns(m), RD_RELEASE_NS), clk_ns);
        inact = imax(ns_to_cyc(recover_ns(m), clk_ns),
                     ns_to_cyc(cycle_min_ns(m), clk_ns) - act);
        rec = imax(1, inact - hold);
        t.setup   = CW'(ns_to_cyc(addr_setup_ns(m), clk_ns));
        t.active  = CW'(act);
        t.hold    = CW'(hold);
        t.recov   = CW'(rec);
        t.rdy_at  = CW'(ns_to_cyc(RDY_SAMPLE_NS, clk_ns));
        t.rdy_max = CW'(ns_to_cyc(RDY_MAX_NS, clk_ns));
        return t;
    endfunction

endpackage

// File: rtl/pio_timing.sv
module pio_timing
    import pio_seq_pkg::*;
#(
    parameter int CLK_NS = 4
) (
    input  logic [2:0]  mode,
    input  logic        wr,
    output pio_timing_t tm
);

    localparam int MAX_MODE = NUM_MODES - 1;

    pio_timing_t tab_wr [NUM_MODES];
    pio_timing_t tab_rd [NUM_MODES];

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        assign tab_wr[m] = mode_timing(m, 1'b1, CLK_NS);
        assign tab_rd[m] = mode_timing(m, 1'b0, CLK_NS);
    end

    logic [2:0] sel;
    assign sel = (int'(mode) > MAX_MODE) ? 3'(MAX_MODE) : mode;   // R12 clamp
    assign tm  = wr ? tab_wr[sel] : tab_rd[sel];

endmodule

// File: rtl/pio_fsm.sv
module pio_fsm
    import pio_seq_pkg::*;
#(
    parameter int CLK_NS = 4,
    parameter int AW     = 3,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          req_wr,
    input  logic [2:0]    req_mode,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  pio_timing_t   tm,
    output logic [2:0]    cur_mode,
    output logic          cur_wr,
    output logic          ack,
    output logic          ack_timeout,
    output logic [DW-1:0] ack_rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd_n,
    output logic          bus_wr_n,
    output logic [DW-1:0] bus_dout,
    output logic          bus_oe,
    input  logic [DW-1:0] bus_din,
    input  logic          bus_rdy
);

    localparam int RD_GAP = ns_to_cyc(RD_RELEASE_NS, CLK_NS);

    phase_t        ph;
    logic [CW-1:0] cnt;
    logic          wr_q;
    logic [2:0]    mode_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wd_q;
    logic [DW-1:0] rd_q;
    logic          low_seen;
    logic          ack_q;
    logic          to_q;
    logic          strobe_on;
    logic          low_seen_nx;

    assign strobe_on   = (ph == PH_STROBE) || (ph == PH_WAIT_READY);
    assign low_seen_nx = (cnt == tm.rdy_at - CW'(1)) ? !bus_rdy : low_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            cnt      <= '0;
            wr_q     <= 1'b0;
            mode_q   <= '0;
            addr_q   <= '0;
            wd_q     <= '0;
            rd_q     <= '0;
            low_seen <= 1'b0;
            ack_q    <= 1'b0;
            to_q     <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            cnt   <= cnt + CW'(1);
            case (ph)
                PH_IDLE: begin
                    cnt <= '0;
                    if (req && !ack_q) begin
                        wr_q   <= req_wr;
                        mode_q <= req_mode;
                        addr_q <= req_addr;
                        wd_q   <= req_wdata;
                        to_q   <= 1'b0;
                        ph     <= PH_ADDR_SETUP;
                    end
                end
                PH_ADDR_SETUP: begin
                    if (cnt == tm.setup - CW'(1)) begin
                        cnt      <= '0;
                        low_seen <= 1'b0;
                        ph       <= PH_STROBE;
                    end
                end
                PH_STROBE: begin
                    low_seen <= low_seen_nx;
                    if (cnt == tm.active - CW'(1)) begin
                        cnt <= '0;
                        if (low_seen_nx && !bus_rdy) begin
                            ph <= PH_WAIT_READY;
                        end else begin
                            rd_q <= bus_din;
                            ph   <= PH_HOLD;
                        end
                    end
                end
                PH_WAIT_READY: begin
                    if (bus_rdy) begin
                        cnt  <= '0;
                        rd_q <= bus_din;
                        ph   <= PH_HOLD;
                    end else if (cnt == tm.rdy_max - CW'(1)) begin
                        cnt  <= '0;
                        rd_q <= bus_din;
                        to_q <= 1'b1;
                        ph   <= PH_HOLD;
                    end
                end
                PH_HOLD: begin
                    if (cnt == tm.hold - CW'(1)) begin
                        cnt <= '0;
                        ph  <= PH_RECOVERY;
                    end
                end
                PH_RECOVERY: begin
                    if (cnt == tm.recov - CW'(1)) begin
                        cnt   <= '0;
                        ack_q <= 1'b1;
                        ph    <= PH_IDLE;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign cur_mode    = mode_q;
    assign cur_wr      = wr_q;
    assign ack         = ack_q;
    assign ack_timeout = ack_q & to_q;
    assign ack_rdata   = rd_q;
    assign bus_addr    = addr_q;
    assign bus_dout    = wd_q;
    assign bus_rd_n    = !(strobe_on && !wr_q);
    assign bus_wr_n    = !(strobe_on && wr_q);
    assign bus_oe      = wr_q && (ph != PH_IDLE) && (ph != PH_RECOVERY);

    // Checker state: strobe run length and cycles since a read strobe ended.
    logic [CW:0]   low_run;
    logic [CW-1:0] since_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run  <= '0;
            since_rd <= CW'(RD_GAP);
        end else begin
            low_run <= strobe_on ? low_run + (CW+1)'(1) : '0;
            if (!bus_rd_n)
                since_rd <= '0;
            else if (int'(since_rd) < RD_GAP)
                since_rd <= since_rd + CW'(1);
        end
    end

    p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        !(!bus_rd_n && !bus_wr_n));

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_IDLE && $past(ph) != PH_IDLE) |-> $stable(bus_addr));

    p_min_width_r3: assert property (@(posedge clk) disable iff (rst)
        (!strobe_on && $past(strobe_on)) |->
        (int'($past(low_run)) + 1 >= int'($past(tm.active))));

    p_wdata_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && $past(bus_oe)) |-> $stable(bus_dout));

    p_wait_bound_r9: assert property (@(posedge clk) disable iff (rst)
        strobe_on |-> (int'(low_run) < int'(tm.active) + int'(tm.rdy_max)));

    p_no_drive_read_r10: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd_n || int'(since_rd) < RD_GAP) |-> !bus_oe);

    p_ack_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

endmodule

// File: rtl/pio_seq.sv
module pio_seq
    import pio_seq_pkg::*;
#(
    parameter int CLK_NS = 4,
    parameter int AW     = 3,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          req_wr,
    input  logic [2:0]    req_mode,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ack,
    output logic          ack_timeout,
    output logic [DW-1:0] ack_rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd_n,
    output logic          bus_wr_n,
    output logic [DW-1:0] bus_dout,
    output logic          bus_oe,
    input  logic [DW-1:0] bus_din,
    input  logic          bus_rdy
);

    pio_timing_t tm;
    logic [2:0]  cur_mode;
    logic        cur_wr;

    pio_timing #(.CLK_NS(CLK_NS)) u_timing (
        .mode (cur_mode),
        .wr   (cur_wr),
        .tm   (tm)
    );

    pio_fsm #(.CLK_NS(CLK_NS), .AW(AW), .DW(DW)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .req_wr      (req_wr),
        .req_mode    (req_mode),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .tm          (tm),
        .cur_mode    (cur_mode),
        .cur_wr      (cur_wr),
        .ack         (ack),
        .ack_timeout (ack_timeout),
        .ack_rdata   (ack_rdata),
        .bus_addr    (bus_addr),
        .bus_rd_n    (bus_rd_n),
        .bus_wr_n    (bus_wr_n),
        .bus_dout    (bus_dout),
        .bus_oe      (bus_oe),
        .bus_din     (bus_din),
        .bus_rdy     (bus_rdy)
    );

endmodule

// File: tb/pio_seq_test.sv
module pio_seq_test;

    localparam int CLK_NS = 4;

    localparam int T0_NS  [5] = '{600, 383, 240, 180, 120};
    localparam int T1_NS  [5] = '{70, 50, 30, 30, 25};
    localparam int T2_NS  [5] = '{290, 290, 290, 80, 70};
    localparam int T2I_NS [5] = '{0, 0, 0, 70, 25};
    localparam int T4_NS  [5] = '{30, 20, 15, 10, 10};
    localparam int T9_NS  [5] = '{20, 15, 10, 10, 10};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic       req_wr = 1'b0;
    logic [2:0] req_mode = '0;
    logic [2:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       ack;
    logic       ack_timeout;
    logic [7:0] ack_rdata;
    logic [2:0] bus_addr;
    logic       bus_rd_n;
    logic       bus_wr_n;
    logic [7:0] bus_dout;
    logic       bus_oe;
    logic [7:0] bus_din = '0;
    logic       bus_rdy = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    int m_setup, m_low, m_hold, m_inact, m_bad, m_ack_after;
    logic [7:0] m_rd;
    logic m_to;

    always #2 clk = ~clk;

    pio_seq #(.CLK_NS(CLK_NS), .AW(3), .DW(8)) uut (
        .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_mode(req_mode),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack),
        .ack_timeout(ack_timeout), .ack_rdata(ack_rdata), .bus_addr(bus_addr),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .bus_din(bus_din), .bus_rdy(bus_rdy)
    );

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int ex_setup(input int m); return cyc(T1_NS[m]); endfunction
    function automatic int ex_width(input int m); return cyc(T2_NS[m]); endfunction
    function automatic int ex_hold(input int m, input bit wr);
        return wr ? cyc(mx(T4_NS[m], T9_NS[m])) : cyc(mx(T9_NS[m], 30));
    endfunction
    function automatic int ex_inact(input int m, input bit wr);
        int i;
        i = mx(cyc(T2I_NS[m]), cyc(T0_NS[m]) - ex_width(m));
        return ex_hold(m, wr) + mx(1, i - ex_hold(m, wr));
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        end
    endtask

    // Run one transaction; bench models the device ready line low during
    // strobe cycles lo_from .. lo_from+lo_len-1 (1-based).
    task automatic run(input bit wr, input int mode, input logic [2:0] a,
                       input logic [7:0] wd, input logic [7:0] dval,
                       input int lo_from, input int lo_len);
        int ph;
        bit strobe;
        bit other;
        int guard;
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_mode = 3'(mode); req_addr = a;
        req_wdata = wd; bus_din = dval; bus_rdy = 1'b1;
        ph = 0; m_setup = 0; m_low = 0; m_hold = 0; m_inact = 0; m_bad = 0;
        guard = 0;
        forever begin
            @(negedge clk);
            guard++;
            strobe = wr ? !bus_wr_n : !bus_rd_n;
            other  = wr ? !bus_rd_n : !bus_wr_n;
            if (other) m_bad++;
            if (bus_addr != a) m_bad++;
            if (!wr && bus_oe) m_bad++;
            if (wr && bus_oe && bus_dout != wd) m_bad++;
            if (ack) begin
                m_rd = ack_rdata; m_to = ack_timeout; req = 1'b0;
                if (ph != 2) m_bad++;
                break;
            end else if (ph == 0) begin
                if (strobe) begin ph = 1; m_low = 1; end
                else m_setup++;
                if (wr && !bus_oe) m_bad++;
            end else if (ph == 1) begin
                if (strobe) m_low++;
                else begin
                    ph = 2; m_inact = 1; bus_din = dval ^ 8'hA5;
                    if (wr && bus_oe) m_hold = 1;
                end
            end else begin
                if (strobe) m_bad++;
                m_inact++;
                if (wr && bus_oe) m_hold++;
            end
            if (ph == 1) bus_rdy = !(m_low >= lo_from && m_low < lo_from + lo_len);
            else bus_rdy = 1'b1;
            if (guard > 3000) begin m_bad++; break; end
        end
        @(negedge clk);
        m_ack_after = int'(ack);
    endtask

    task automatic t_reset();
        check("R1 rd_n in reset", int'(bus_rd_n), 1);
        check("R1 wr_n in reset", int'(bus_wr_n), 1);
        check("R1 oe in reset", int'(bus_oe), 0);
        check("R1 ack in reset", int'(ack), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 idle strobes after reset", int'(bus_rd_n & bus_wr_n), 1);
        check("R1 idle oe after reset", int'(bus_oe), 0);
    endtask

    task automatic t_write_all();
        for (int m = 0; m < 5; m++) begin
            run(1'b1, m, 3'(m + 1), 8'(8'h30 + m), 8'h00, 0, 0);
            check($sformatf("R2 write setup mode %0d", m), m_setup, ex_setup(m));
            check($sformatf("R3 write width mode %0d", m), m_low, ex_width(m));
            check($sformatf("R5 write hold mode %0d", m), m_hold, ex_hold(m, 1'b1));
            check($sformatf("R4 write inactive mode %0d", m), m_inact, ex_inact(m, 1'b1));
            check($sformatf("R4 cycle time mode %0d", m),
                  int'(m_low + m_inact >= cyc(T0_NS[m])), 1);
            check($sformatf("R2 bus rules write mode %0d", m), m_bad, 0);
            check($sformatf("R9 no timeout write mode %0d", m), int'(m_to), 0);
            check($sformatf("R11 ack one cycle mode %0d", m), m_ack_after, 0);
        end
    endtask

    task automatic t_read_all();
        for (int m = 0; m < 5; m++) begin
            run(1'b0, m, 3'(6 - m), 8'h00, 8'(8'hC0 + m), 0, 0);
            check($sformatf("R6 read data mode %0d", m), int'(m_rd), 'hC0 + m);
            check($sformatf("R2 read setup mode %0d", m), m_setup, ex_setup(m));
            check($sformatf("R3 read width mode %0d", m), m_low, ex_width(m));
            check($sformatf("R4 read inactive mode %0d", m), m_inact, ex_inact(m, 1'b0));
            check($sformatf("R10 read inactive covers release mode %0d", m),
                  int'(m_inact >= cyc(30)), 1);
            check($sformatf("R10 bus rules read mode %0d", m), m_bad, 0);
        end
    endtask

    task automatic t_ready_stretch();
        run(1'b0, 4, 3'd2, 8'h00, 8'h5E, 1, 40);
        check("R7 read stretched width", m_low, 41);
        check("R7 read stretched data", int'(m_rd), 'h5E);
        check("R7 no timeout", int'(m_to), 0);
        run(1'b1, 3, 3'd4, 8'h77, 8'h00, 1, 30);
        check("R7 write stretched width", m_low, 31);
        check("R7 write stretched hold", m_hold, ex_hold(3, 1'b1));
        check("R7 bus rules", m_bad, 0);
    endtask

    task automatic t_ready_ignored();
        run(1'b0, 4, 3'd1, 8'h00, 8'h11, 1, 5);
        check("R8 short low width", m_low, ex_width(4));
        run(1'b0, 4, 3'd1, 8'h00, 8'h12, 12, 20);
        check("R8 low after sample width", m_low, ex_width(4));
        run(1'b1, 4, 3'd1, 8'h99, 8'h00, 5, 10);
        check("R8 low gone by width end", m_low, ex_width(4));
        check("R8 no timeout", int'(m_to), 0);
    endtask

    task automatic t_timeout();
        run(1'b0, 4, 3'd3, 8'h00, 8'hE7, 1, 100000);
        check("R9 read timeout width", m_low, ex_width(4) + cyc(1250));
        check("R9 read timeout flag", int'(m_to), 1);
        check("R9 read timeout data", int'(m_rd), 'hE7);
        run(1'b1, 0, 3'd5, 8'h3C, 8'h00, 1, 100000);
        check("R9 write timeout width", m_low, ex_width(0) + cyc(1250));
        check("R9 write timeout flag", int'(m_to), 1);
        check("R9 write timeout bus rules", m_bad, 0);
        run(1'b1, 4, 3'd5, 8'h3D, 8'h00, 0, 0);
        check("R9 flag clears next cycle", int'(m_to), 0);
    endtask

    task automatic t_clamp();
        for (int m = 5; m < 8; m++) begin
            run(1'b1, m, 3'd7, 8'hA0, 8'h00, 0, 0);
            check($sformatf("R12 mode %0d setup", m), m_setup, ex_setup(4));
            check($sformatf("R12 mode %0d width", m), m_low, ex_width(4));
            check($sformatf("R12 mode %0d inactive", m), m_inact, ex_inact(4, 1'b1));
        end
    endtask

    task automatic t_back_to_back();
        run(1'b0, 3, 3'd2, 8'h00, 8'h42, 0, 0);
        check("R11 first read data", int'(m_rd), 'h42);
        run(1'b1, 3, 3'd6, 8'h24, 8'h00, 0, 0);
        check("R11 following write setup", m_setup, ex_setup(3));
        check("R11 following write width", m_low, ex_width(3));
        check("R11 following write rules", m_bad, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_write_all();
        t_read_all();
        t_ready_stretch();
        t_ready_ignored();
        t_timeout();
        t_clamp();
        t_back_to_back();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        summary();
        $finish;
    end

endmodule